// File: doc/BRIEF.md
# Two-State Accumulator Processor

A compact 16-bit processor built around a single working register (the accumulator). A two-state controller alternates between a fetch phase, which reads the word addressed by the program counter into the instruction register and advances the counter, and an execute phase, which decodes the top four bits of that word and applies the operation to the accumulator, to memory or to the program counter. The lower twelve bits of every instruction name a memory word. Programs and data share one internal word memory.

All architectural registers change on the rising clock edge. The memory is read and written on the falling edge, so the word a phase needs is ready before that phase ends. Every instruction except stop therefore costs exactly two cycles. A stop leaves the machine parked in its execute phase.

The memory is filled through a load port that acts only while reset is held. The program counter, instruction register, accumulator and controller phase are brought out for observation.

Top module: `accum_cpu`

## Requirements
- R1: A synchronous active-high reset sets the program counter, instruction register and accumulator to zero and puts the controller in fetch (state output 0).
- R2: Fetch always leads to execute (state output 1). At the end of fetch the instruction register holds the memory word at the old program counter, and the program counter is one higher, wrapping at 12 bits.
- R3: Opcode 0 (bits 15:12) loads the accumulator from the memory word at the operand address (bits 11:0). The new value appears at the rising edge that returns the controller to fetch, and the accumulator never changes during fetch.
- R4: Opcode 1 writes the accumulator into the memory word at the operand address. A later opcode 0 from that address returns the stored value.
- R5: Opcode 2 adds the memory word at the operand address to the accumulator, and opcode 3 subtracts it, both modulo 2^16.
- R6: Opcode 4 loads the operand address into the program counter.
- R7: Opcode 5 loads the operand address into the program counter only when accumulator bit 15 is 0. Opcode 6 does so only when the accumulator is non-zero. Otherwise the program counter keeps its incremented value.
- R8: Opcode 7 keeps the controller in execute indefinitely, with the program counter, instruction register and accumulator unchanged.
- R9: Opcodes 8 to 15 change neither the accumulator nor memory, and execution continues at the next word.
- R10: Load-port writes are honoured only while reset is asserted. A load strobe during execution leaves memory unchanged.
- R11: Every instruction other than opcode 7 returns the controller from execute to fetch after one cycle, so it takes two cycles in total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers on the rising edge, memory on the falling edge |
| rst | input | 1 | Synchronous active-high reset; also enables the load port |
| ld_we | input | 1 | Load-port write strobe, used only during reset |
| ld_addr | input | 12 | Load-port word address |
| ld_data | input | 16 | Load-port write data |
| pc_o | output | 12 | Program counter |
| ir_o | output | 16 | Instruction register |
| acc_o | output | 16 | Accumulator |
| state_o | output | 1 | Controller state: 0 fetch, 1 execute |

## Verification
After reset is released, the instruction register and the incremented program counter are due at the first rising edge. The accumulator result, any jump target and the return to fetch are due at the second rising edge. The bench keeps a word-level model of the memory and registers, steps it once per phase, and compares the ports at the falling edge after each rising edge, where the registered outputs are settled and no edge is being processed. A stop is followed for several extra cycles to confirm that nothing moves. An attempted load during execution is checked through a later load of the same word.

// File: rtl/accum_cpu_pkg.sv
package accum_cpu_pkg;

  localparam int OP_W = 4;

  typedef enum logic {
    ST_FETCH = 1'b0,
    ST_EXEC  = 1'b1
  } state_t;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 4'd0,
    OP_STORE = 4'd1,
    OP_ADD   = 4'd2,
    OP_SUB   = 4'd3,
    OP_JUMP  = 4'd4,
    OP_JPOS  = 4'd5,
    OP_JNZ   = 4'd6,
    OP_HALT  = 4'd7
  } opcode_t;

  typedef enum logic [1:0] {
    ALU_INC,
    ALU_PASS_Y,
    ALU_ADD,
    ALU_SUB
  } alu_op_t;

  typedef struct packed {
    logic    pc_en;
    logic    ir_en;
    logic    acc_en;
    logic    x_from_acc;
    logic    y_from_ir;
    logic    addr_from_ir;
    logic    mem_we;
    alu_op_t alu_op;
    state_t  next_state;
  } ctrl_t;

endpackage

// File: rtl/accum_cpu_alu.sv
module accum_cpu_alu
  import accum_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] y_in,
  input  alu_op_t           op,
  output logic [DATA_W-1:0] z_out
);

  always_comb begin
    unique case (op)
      ALU_INC:    z_out = x_in + DATA_W'(1);
      ALU_PASS_Y: z_out = y_in;
      ALU_ADD:    z_out = x_in + y_in;
      ALU_SUB:    z_out = x_in - y_in;
      default:    z_out = y_in;
    endcase
  end

endmodule

// File: rtl/accum_cpu_ctrl.sv
module accum_cpu_ctrl
  import accum_cpu_pkg::*;
(
  input  state_t  state,
  input  opcode_t opcode,
  input  logic    acc_neg,
  input  logic    acc_zero,
  output ctrl_t   ctrl
);

  always_comb begin
    ctrl              = '0;
    ctrl.alu_op       = ALU_PASS_Y;
    ctrl.next_state   = ST_FETCH;
    if (state == ST_FETCH) begin
      ctrl.pc_en        = 1'b1;
      ctrl.ir_en        = 1'b1;
      ctrl.alu_op       = ALU_INC;
      ctrl.next_state   = ST_EXEC;
    end else begin
      ctrl.addr_from_ir = 1'b1;
      ctrl.x_from_acc   = 1'b1;
      case (opcode)
        OP_LOAD: begin
          ctrl.acc_en = 1'b1;
          ctrl.alu_op = ALU_PASS_Y;
        end
        OP_STORE: ctrl.mem_we = 1'b1;
        OP_ADD: begin
          ctrl.acc_en = 1'b1;
          ctrl.alu_op = ALU_ADD;
        end
        OP_SUB: begin
          ctrl.acc_en = 1'b1;
          ctrl.alu_op = ALU_SUB;
        end
        OP_JUMP: begin
          ctrl.pc_en     = 1'b1;
          ctrl.y_from_ir = 1'b1;
        end
        OP_JPOS: begin
          ctrl.pc_en     = ~acc_neg;
          ctrl.y_from_ir = 1'b1;
        end
        OP_JNZ: begin
          ctrl.pc_en     = ~acc_zero;
          ctrl.y_from_ir = 1'b1;
        end
        OP_HALT: ctrl.next_state = ST_EXEC;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/accum_cpu_mem.sv
module accum_cpu_mem #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] store_q [WORDS];

  always_ff @(negedge clk) begin
    if (we) store_q[addr] <= wdata;
    rdata <= store_q[addr];
  end

endmodule

// File: rtl/accum_cpu.sv
module accum_cpu
  import accum_cpu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = ADDR_W + OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              state_o
);

  localparam int PAD_W = DATA_W - ADDR_W;

  state_t            state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] acc_q;

  ctrl_t             ctrl;
  logic [DATA_W-1:0] dbus;
  logic [DATA_W-1:0] x_bus;
  logic [DATA_W-1:0] y_bus;
  logic [DATA_W-1:0] z_bus;
  logic [ADDR_W-1:0] a_bus;
  logic [ADDR_W-1:0] ir_addr;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  assign ir_addr = ir_q[ADDR_W-1:0];

  accum_cpu_ctrl i_ctrl (
    .state    (state_q),
    .opcode   (opcode_t'(ir_q[DATA_W-1 -: OP_W])),
    .acc_neg  (acc_q[DATA_W-1]),
    .acc_zero (acc_q == '0),
    .ctrl     (ctrl)
  );

  // Datapath multiplexers
  assign a_bus = ctrl.addr_from_ir ? ir_addr : pc_q;
  assign x_bus = ctrl.x_from_acc ? acc_q : {{PAD_W{1'b0}}, pc_q};
  assign y_bus = ctrl.y_from_ir ? {{PAD_W{1'b0}}, ir_addr} : dbus;

  accum_cpu_alu #(.DATA_W(DATA_W)) i_alu (
    .x_in  (x_bus),
    .y_in  (y_bus),
    .op    (ctrl.alu_op),
    .z_out (z_bus)
  );

  // The load port owns the memory while reset is held
  assign mem_we    = rst ? ld_we : ctrl.mem_we;
  assign mem_addr  = rst ? ld_addr : a_bus;
  assign mem_wdata = rst ? ld_data : acc_q;

  accum_cpu_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (dbus)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
    end else begin
      state_q <= ctrl.next_state;
      if (ctrl.pc_en)  pc_q  <= z_bus[ADDR_W-1:0];
      if (ctrl.ir_en)  ir_q  <= dbus;
      if (ctrl.acc_en) acc_q <= z_bus;
    end
  end

  assign pc_o    = pc_q;
  assign ir_o    = ir_q;
  assign acc_o   = acc_q;
  assign state_o = state_q;

endmodule

// File: rtl/accum_cpu_chk.sv
module accum_cpu_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] ir,
  input logic [DATA_W-1:0] acc,
  input logic              state
);

  logic [3:0] op;
  logic       rst_seen_q = 1'b0;

  assign op = ir[DATA_W-1 -: 4];

  always_ff @(posedge clk) rst_seen_q <= rst;

  always @(negedge clk) begin
    if (rst_seen_q) begin
      assert_reset_R1: assert (pc == '0 && ir == '0 && acc == '0 && state == 1'b0)
        else $error("reset state wrong");
    end
  end

  assert_fetch_exec_R2: assert property (@(posedge clk) disable iff (rst)
    (state == 1'b0) |=> (state == 1'b1) && (pc == $past(pc) + ADDR_W'(1)));

  assert_fetch_keeps_acc_R3: assert property (@(posedge clk) disable iff (rst)
    (state == 1'b0) |=> $stable(acc));

  assert_jump_R6: assert property (@(posedge clk) disable iff (rst)
    (state == 1'b1 && op == 4'd4) |=> (pc == $past(ir[ADDR_W-1:0])));

  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (state == 1'b1 && op == 4'd7) |=>
      (state == 1'b1) && $stable(pc) && $stable(ir) && $stable(acc));

  assert_nop_R9: assert property (@(posedge clk) disable iff (rst)
    (state == 1'b1 && op[3]) |=> $stable(acc) && $stable(pc));

  assert_exec_return_R11: assert property (@(posedge clk) disable iff (rst)
    (state == 1'b1 && op != 4'd7) |=> (state == 1'b0));

endmodule

bind accum_cpu accum_cpu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk   (clk),
  .rst   (rst),
  .pc    (pc_o),
  .ir    (ir_o),
  .acc   (acc_o),
  .state (state_o)
);

// File: tb/test_accum_cpu.sv
module test_accum_cpu;

  localparam int CLK_P  = 10;
  localparam int AW     = 12;
  localparam int DW     = 16;
  localparam int LOAD_N = 512;
  localparam int STEPS  = 100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [AW-1:0] pc_o;
  logic [DW-1:0] ir_o;
  logic [DW-1:0] acc_o;
  logic          state_o;

  int nvec = 0;
  int nfail = 0;

  logic [DW-1:0] mm [4096];
  logic [AW-1:0] mpc;
  logic [DW-1:0] macc;

  always #(CLK_P/2) clk = ~clk;

  accum_cpu i_accum_cpu (
    .clk     (clk),
    .rst     (rst),
    .ld_we   (ld_we),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .pc_o    (pc_o),
    .ir_o    (ir_o),
    .acc_o   (acc_o),
    .state_o (state_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'd0:       return "R3";
      4'd1:       return "R4";
      4'd2, 4'd3: return "R5";
      4'd4:       return "R6";
      4'd5, 4'd6: return "R7";
      4'd7:       return "R8";
      default:    return "R9";
    endcase
  endfunction

  function automatic logic [DW-1:0] enc(input logic [3:0] op, input logic [AW-1:0] a);
    return {op, a};
  endfunction

  // Load mm[0..LOAD_N-1] through the port under reset, then check the reset state
  task automatic load_mem();
    rst = 1'b1;
    for (int i = 0; i < LOAD_N; i++) begin
      @(posedge clk); #1;
      ld_we = 1'b1; ld_addr = AW'(i); ld_data = mm[i];
    end
    @(posedge clk); #1;
    ld_we = 1'b0;
    @(negedge clk);
    chk("R1 pc", 32'(pc_o), 0);
    chk("R1 ir", 32'(ir_o), 0);
    chk("R1 acc", 32'(acc_o), 0);
    chk("R1 state", 32'(state_o), 0);
  endtask

  // Release reset and run the model alongside the design
  task automatic run(input bit directed);
    logic [DW-1:0] w;
    logic [3:0]    op;
    logic [AW-1:0] a;
    @(posedge clk); #1;
    rst = 1'b0;
    if (directed) begin
      ld_we = 1'b1; ld_addr = AW'(20); ld_data = 16'h1234;
    end
    mpc = '0; macc = '0;
    for (int s = 0; s < STEPS; s++) begin
      w = mm[mpc];
      @(posedge clk); @(negedge clk);
      chk("R2 state", 32'(state_o), 1);
      chk("R2 ir", 32'(ir_o), 32'(w));
      chk("R2 pc", 32'(pc_o), 32'(AW'(mpc + 1'b1)));
      mpc = mpc + 1'b1;
      op = w[15:12]; a = w[11:0];
      if (op == 4'd7) begin
        for (int k = 0; k < 4; k++) begin
          @(posedge clk); @(negedge clk);
          chk("R8 state", 32'(state_o), 1);
          chk("R8 pc", 32'(pc_o), 32'(mpc));
          chk("R8 ir", 32'(ir_o), 32'(w));
          chk("R8 acc", 32'(acc_o), 32'(macc));
        end
        break;
      end
      case (op)
        4'd0: macc = mm[a];
        4'd1: mm[a] = macc;
        4'd2: macc = macc + mm[a];
        4'd3: macc = macc - mm[a];
        4'd4: mpc = a;
        4'd5: if (!macc[15]) mpc = a;
        4'd6: if (macc != '0) mpc = a;
        default: ;
      endcase
      @(posedge clk); @(negedge clk);
      chk("R11 state", 32'(state_o), 0);
      chk(op_tag(op), 32'(acc_o), 32'(macc));
      chk(op_tag(op), 32'(pc_o), 32'(mpc));
      if (directed && s == 0) begin
        chk("R10 ignored load", 32'(acc_o), 32'h7FFF);
        #1 ld_we = 1'b0;
      end
    end
    ld_we = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) mm[i] = '0;

    // Directed program: overflow, sign and zero tests for the conditional jumps
    mm[0]  = enc(4'd0, 12'd20);  // acc = 7FFF
    mm[1]  = enc(4'd2, 12'd21);  // acc = 8000
    mm[2]  = enc(4'd5, 12'd30);  // not taken, negative
    mm[3]  = enc(4'd6, 12'd5);   // taken, non-zero
    mm[4]  = enc(4'd7, 12'd0);
    mm[5]  = enc(4'd3, 12'd22);  // acc = 0
    mm[6]  = enc(4'd6, 12'd30);  // not taken, zero
    mm[7]  = enc(4'd5, 12'd9);   // taken, non-negative
    mm[8]  = enc(4'd7, 12'd0);
    mm[9]  = enc(4'd1, 12'd23);  // store 0
    mm[10] = enc(4'd0, 12'd21);  // acc = 1
    mm[11] = enc(4'd0, 12'd23);  // acc = 0 from stored word
    mm[12] = 16'h9ABC;           // no-op
    mm[13] = enc(4'd4, 12'd15);
    mm[14] = enc(4'd7, 12'd0);
    mm[15] = enc(4'd3, 12'd21);  // acc = FFFF
    mm[16] = enc(4'd7, 12'd0);
    mm[20] = 16'h7FFF;
    mm[21] = 16'h0001;
    mm[22] = 16'h8000;
    mm[23] = 16'h5555;
    load_mem();
    run(1'b1);

    // Random programs with rare stops
    for (int p = 0; p < 5; p++) begin
      for (int i = 0; i < LOAD_N; i++) begin
        logic [3:0] op;
        op = 4'($urandom % 16);
        if (op == 4'd7 && ($urandom % 6) != 0) op = 4'd2;
        mm[i] = {op, 4'd0, 8'($urandom)};
      end
      load_mem();
      run(1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule